// File: doc/BRIEF.md
# Host Bus Port for a Character Display Controller

This block sits between a host processor and the instruction executor of a character display controller. The host drives a register select line, a read/write line, an asynchronous enable strobe and eight data lines. The block brings the strobe into the system clock domain. It sorts each host cycle into one of four kinds: instruction write, status read, data write or data read. Each finished write byte is passed to the executor as a one-cycle command.

A function-set instruction switches the block at run time between whole-byte transfers and two-transfer nibble transfers. In nibble mode only data lines 7..4 carry information, and the upper nibble goes first. A status read returns the executor's busy flag together with its address counter. A data read returns a local data register. After each completed data read, the block asks the executor for the next RAM byte and loads the returned byte into that register. The first read after an address move therefore returns whatever the register held before.

The data lines are presented as a separate output value and an output-enable, for a pad ring to combine.

Top module: `lcdp_host_port`

## Requirements
- R1: With select=0 and read/write=0, a completed byte is issued as a command with `cmd_is_data`=0. With select=1 and read/write=0, it is issued with `cmd_is_data`=1. Status reads and data reads issue no command.
- R2: A status read (select=0, read/write=1) returns the executor busy flag on bit 7 and the 7-bit address counter on bits 6:0. An instruction written earlier never shows on this read.
- R3: After reset the port is in whole-byte mode. Each falling edge of the enable strobe completes one byte, which is taken from data lines 7..0.
- R4: An instruction byte whose bits 7:5 are 001 sets the transfer width from its bit 4: 1 selects whole-byte transfers and 0 selects nibble transfers. The new width applies from the next transfer.
- R5: In nibble mode a byte is formed from two transfers on lines 7..4, upper nibble first. The first transfer issues no command, so the executor cannot go busy before the second transfer.
- R6: In nibble mode a read gives the upper nibble of the byte on lines 7..4 in the first transfer and the lower nibble in the second. Lines 3..0 read as 0.
- R7: A data read returns the data register. Each completed data read raises `fetch_req` for exactly one cycle. A `fetch_valid` pulse loads `fetch_data` into the data register. Status reads raise no `fetch_req`.
- R8: `bus_oe` is high only while the synchronised enable is high and read/write=1. The synchroniser has two stages, so `bus_oe` follows a rising strobe two clocks later.
- R9: Reset, and any width change by a function-set instruction, put the nibble sequence back to the upper nibble.
- R10: `cmd_valid` is a single-cycle pulse, with at most one pulse per completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Asynchronous enable strobe from the host |
| bus_din | input | 8 | Data lines as driven by the host |
| bus_dout | output | 8 | Value to place on the data lines during reads |
| bus_oe | output | 1 | Drive enable for the data lines |
| cmd_valid | output | 1 | One-cycle pulse: a write byte is complete |
| cmd_is_data | output | 1 | Command came from a data write |
| cmd_byte | output | 8 | Assembled write byte |
| fetch_req | output | 1 | One-cycle request for the next RAM byte |
| fetch_valid | input | 1 | Executor returns a RAM byte |
| fetch_data | input | 8 | RAM byte from the executor |
| exec_busy | input | 1 | Executor busy flag |
| exec_ac | input | 7 | Executor address counter |

## Verification
A wrong nibble phase or width flag shows up on the very next read, because the bus then carries the wrong half of the byte. It also shows up on the next write, as a command that fires one transfer early or late, or that carries a byte with its halves swapped. A data register that is loaded at the wrong time is seen on the following data read. A missed or doubled `fetch_req` is seen within three clocks of the strobe falling. An output-enable that is held too long shows as a mismatch on the first clock after the synchronised strobe drops.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
  localparam int LCDP_DW  = 8;
  localparam int LCDP_ACW = LCDP_DW - 1;
  localparam int LCDP_NIB = LCDP_DW / 2;

  typedef enum logic [1:0] {
    ACC_IWR  = 2'b00,
    ACC_STAT = 2'b01,
    ACC_DWR  = 2'b10,
    ACC_DRD  = 2'b11
  } acc_e;

  function automatic acc_e acc_kind(input logic rs, input logic rw);
    return acc_e'({rs, rw});
  endfunction

  function automatic logic is_width_cmd(input logic [LCDP_DW-1:0] b);
    return b[LCDP_DW-1:LCDP_DW-3] == 3'b001;
  endfunction

  function automatic logic [LCDP_NIB-1:0] nib_pick(input logic [LCDP_DW-1:0] b,
                                                   input logic lower);
    return lower ? b[LCDP_NIB-1:0] : b[LCDP_DW-1:LCDP_NIB];
  endfunction

  function automatic logic [LCDP_DW-1:0] pack_status(input logic busy,
                                                     input logic [LCDP_ACW-1:0] ac);
    return {busy, ac};
  endfunction
endpackage

// File: rtl/lcdp_strobe_sync.sv
module lcdp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic en_level,
  output logic en_fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[g] <= 1'b0;
        else        sh[g] <= en_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh[g] <= 1'b0;
        else        sh[g] <= sh[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sh[STAGES-1];

  assign en_level = sh[STAGES-1];
  assign en_fall  = prev & ~sh[STAGES-1];
endmodule

// File: rtl/lcdp_xfer_ctl.sv
module lcdp_xfer_ctl
  import lcdp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fall,
  input  logic               rs,
  input  logic               rw,
  input  logic [LCDP_DW-1:0] din,
  output logic               wide,
  output logic               phase,
  output logic               cmd_valid,
  output logic               cmd_is_data,
  output logic [LCDP_DW-1:0] cmd_byte,
  output logic               fetch_req
);
  logic [LCDP_NIB-1:0] hi_q;
  logic [LCDP_DW-1:0]  assembled;
  logic                byte_done;
  logic                first_half;
  acc_e                kind;

  assign kind       = acc_kind(rs, rw);
  assign assembled  = wide ? din : {hi_q, nib_pick(din, 1'b0)};
  assign byte_done  = fall & (wide | phase);
  assign first_half = fall & ~wide & ~phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide        <= 1'b1;
      phase       <= 1'b0;
      hi_q        <= '0;
      cmd_valid   <= 1'b0;
      cmd_is_data <= 1'b0;
      cmd_byte    <= '0;
      fetch_req   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      fetch_req <= 1'b0;
      if (first_half) begin
        hi_q  <= nib_pick(din, 1'b0);
        phase <= 1'b1;
      end
      if (byte_done) begin
        phase <= 1'b0;
        case (kind)
          ACC_IWR: begin
            cmd_valid   <= 1'b1;
            cmd_is_data <= 1'b0;
            cmd_byte    <= assembled;
            if (is_width_cmd(assembled)) begin
              wide <= assembled[LCDP_NIB];
              if (assembled[LCDP_NIB] != wide) phase <= 1'b0;
            end
          end
          ACC_DWR: begin
            cmd_valid   <= 1'b1;
            cmd_is_data <= 1'b1;
            cmd_byte    <= assembled;
          end
          ACC_DRD:  fetch_req <= 1'b1;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcdp_read_path.sv
module lcdp_read_path
  import lcdp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_valid,
  input  logic [LCDP_DW-1:0]  fetch_data,
  input  logic                busy,
  input  logic [LCDP_ACW-1:0] ac,
  input  logic                rs,
  input  logic                rw,
  input  logic                level,
  input  logic                wide,
  input  logic                phase,
  output logic [LCDP_DW-1:0]  dout,
  output logic                oe
);
  logic [LCDP_DW-1:0] data_q;
  logic [LCDP_DW-1:0] full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           data_q <= '0;
    else if (fetch_valid) data_q <= fetch_data;

  assign full = rs ? data_q : pack_status(busy, ac);
  assign oe   = level & rw;

  always_comb begin
    if (!oe)       dout = '0;
    else if (wide) dout = full;
    else           dout = {nib_pick(full, phase), {LCDP_NIB{1'b0}}};
  end
endmodule

// File: rtl/lcdp_host_port.sv
module lcdp_host_port
  import lcdp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rs,
  input  logic                bus_rw,
  input  logic                bus_en,
  input  logic [LCDP_DW-1:0]  bus_din,
  output logic [LCDP_DW-1:0]  bus_dout,
  output logic                bus_oe,
  output logic                cmd_valid,
  output logic                cmd_is_data,
  output logic [LCDP_DW-1:0]  cmd_byte,
  output logic                fetch_req,
  input  logic                fetch_valid,
  input  logic [LCDP_DW-1:0]  fetch_data,
  input  logic                exec_busy,
  input  logic [LCDP_ACW-1:0] exec_ac
);
  logic strobe_level;
  logic strobe_fall;
  logic wide_mode;
  logic nib_phase;

  lcdp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en_async(bus_en),
    .en_level(strobe_level), .en_fall(strobe_fall)
  );

  lcdp_xfer_ctl u_xfer (
    .clk(clk), .rst_n(rst_n), .fall(strobe_fall),
    .rs(bus_rs), .rw(bus_rw), .din(bus_din),
    .wide(wide_mode), .phase(nib_phase),
    .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data),
    .cmd_byte(cmd_byte), .fetch_req(fetch_req)
  );

  lcdp_read_path u_read (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .busy(exec_busy), .ac(exec_ac),
    .rs(bus_rs), .rw(bus_rw), .level(strobe_level),
    .wide(wide_mode), .phase(nib_phase),
    .dout(bus_dout), .oe(bus_oe)
  );
endmodule

// File: rtl/lcdp_host_port_chk.sv
module lcdp_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rs,
  input logic       bus_rw,
  input logic       strobe_fall,
  input logic       wide_mode,
  input logic       nib_phase,
  input logic       cmd_valid,
  input logic       fetch_req,
  input logic       bus_oe,
  input logic [7:0] bus_dout
);
  // A command only follows a detected strobe fall (R3)
  assert_cmd_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(strobe_fall));

  // A first nibble never produces a command (R5)
  assert_no_cmd_first_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_fall && !wide_mode && !nib_phase) |=> !cmd_valid);

  // Lower lines are quiet during nibble reads (R6)
  assert_low_lines_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !wide_mode) |-> (bus_dout[3:0] == 4'h0));

  // A fetch only follows a fall seen with a data read (R7)
  assert_fetch_on_data_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> $past(strobe_fall && bus_rs && bus_rw));

  // The bus is driven only for reads (R8)
  assert_oe_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> bus_rw);

  // A command lasts one cycle (R10)
  assert_cmd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
endmodule

bind lcdp_host_port lcdp_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_rw(bus_rw),
  .strobe_fall(strobe_fall), .wide_mode(wide_mode), .nib_phase(nib_phase),
  .cmd_valid(cmd_valid), .fetch_req(fetch_req), .bus_oe(bus_oe),
  .bus_dout(bus_dout)
);

// File: tb/lcdp_host_port_bench.sv
module lcdp_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rs = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic       cmd_valid, cmd_is_data, fetch_req;
  logic [7:0] cmd_byte;
  logic       fetch_valid = 1'b0;
  logic [7:0] fetch_data = 8'h00;
  logic       exec_busy = 1'b0;
  logic [6:0] exec_ac = 7'h00;

  int checks = 0, errors = 0;
  int cmd_seen = 0, fetch_seen = 0, fetch_exp = 0;
  logic       dl_m = 1'b1, ph_m = 1'b0;
  logic [3:0] hi_m = 4'h0;
  logic [7:0] dreg_m = 8'h00, next_fetch = 8'hA0;
  logic [8:0] exp_q[$];
  logic       e1 = 1'b0, e2 = 1'b0;
  bit         done_flag = 1'b0;

  always #5 clk = ~clk;

  lcdp_host_port u_lcdp_host_port (
    .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_en(bus_en), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data), .cmd_byte(cmd_byte),
    .fetch_req(fetch_req), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .exec_busy(exec_busy), .exec_ac(exec_ac)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // two-clock delay of the strobe as seen by the port (R8)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin e1 <= 1'b0; e2 <= 1'b0; end
    else begin e1 <= bus_en; e2 <= e1; end

  // reference monitor compared on every clock
  always @(negedge clk) if (rst_n) begin
    chk(bus_oe == (e2 & bus_rw), "R8 oe timing", {8'h0, bus_oe}, {8'h0, e2 & bus_rw});
    if (cmd_valid) begin
      cmd_seen++;
      if (exp_q.size() == 0)
        chk(1'b0, "R1 unexpected command", {cmd_is_data, cmd_byte}, 9'h0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({cmd_is_data, cmd_byte} == e, "R1 command content", {cmd_is_data, cmd_byte}, e);
      end
    end
    fetch_valid = 1'b0;
    if (fetch_req) begin
      fetch_seen++;
      fetch_valid = 1'b1;
      fetch_data  = next_fetch;
      dreg_m      = next_fetch;
      next_fetch  = next_fetch + 8'h11;
    end
  end

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] lines,
                      input string tag);
    logic [7:0] full, exp_l, asm;
    logic       done;
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_din = rw ? 8'h00 : lines;
    full  = rs ? dreg_m : {exec_busy, exec_ac};
    exp_l = dl_m ? full : (ph_m ? {full[3:0], 4'h0} : {full[7:4], 4'h0});
    @(negedge clk); bus_en = 1'b1;
    repeat (3) @(negedge clk);
    if (rw) chk(bus_oe && bus_dout == exp_l, tag, {bus_oe, bus_dout}, {1'b1, exp_l});
    bus_en = 1'b0;
    done = dl_m | ph_m;
    asm  = dl_m ? lines : {hi_m, lines[7:4]};
    if (!dl_m) begin
      if (!ph_m) hi_m = lines[7:4];
      ph_m = ~ph_m;
    end
    if (done) begin
      ph_m = 1'b0;
      if (!rw) exp_q.push_back({rs, asm});
      if (rw && rs) fetch_exp++;
      if (!rw && !rs && asm[7:5] == 3'b001) dl_m = asm[4];
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic put_byte(input logic rs, input logic [7:0] b, input string tag);
    if (dl_m) xfer(rs, 1'b0, b, tag);
    else begin
      xfer(rs, 1'b0, {b[7:4], 4'h0}, tag);
      xfer(rs, 1'b0, {b[3:0], 4'h0}, tag);
    end
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0, f0;
    repeat (3) @(negedge clk);
    // reset state
    chk(!bus_oe && !cmd_valid && !fetch_req, "R3 reset outputs",
        {bus_oe, cmd_valid, 7'h0}, 9'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // whole-byte status reads after reset
    xfer(1'b0, 1'b1, 8'h00, "R3 reset width status");
    exec_busy = 1'b1; exec_ac = 7'h5A;
    xfer(1'b0, 1'b1, 8'h00, "R2 status busy+ac");
    // writes of both kinds
    put_byte(1'b0, 8'h0C, "R1 instruction write");
    put_byte(1'b1, 8'h41, "R1 data write");
    exec_busy = 1'b0; exec_ac = 7'h01;
    xfer(1'b0, 1'b1, 8'h00, "R2 status not instruction");
    // data reads with prefetch
    xfer(1'b1, 1'b1, 8'h00, "R7 stale first read");
    xfer(1'b1, 1'b1, 8'h00, "R7 prefetched read");
    f0 = fetch_seen;
    xfer(1'b0, 1'b1, 8'h00, "R7 status read");
    chk(fetch_seen == f0, "R7 no fetch on status", fetch_seen[8:0], f0[8:0]);
    chk(fetch_seen == fetch_exp, "R7 one fetch per read", fetch_seen[8:0], fetch_exp[8:0]);
    // switch to nibble mode (R4)
    put_byte(1'b0, 8'h28, "R4 width to nibble");
    exec_busy = 1'b0; exec_ac = 7'h27;
    xfer(1'b0, 1'b1, 8'h00, "R9 R6 first nibble high");
    xfer(1'b0, 1'b1, 8'h00, "R6 second nibble low");
    // first nibble issues nothing (R5)
    c0 = cmd_seen;
    xfer(1'b0, 1'b0, 8'h00, "R5 first nibble");
    chk(cmd_seen == c0, "R5 no command after first nibble", cmd_seen[8:0], c0[8:0]);
    xfer(1'b0, 1'b0, 8'hF0, "R5 second nibble");
    chk(cmd_seen == c0 + 1, "R5 command after second nibble", cmd_seen[8:0], 9'(c0 + 1));
    put_byte(1'b1, 8'hB7, "R5 nibble data write");
    // nibble data read: one fetch only after second half
    f0 = fetch_seen;
    xfer(1'b1, 1'b1, 8'h00, "R6 data high nibble");
    chk(fetch_seen == f0, "R7 no fetch mid byte", fetch_seen[8:0], f0[8:0]);
    xfer(1'b1, 1'b1, 8'h00, "R6 data low nibble");
    chk(fetch_seen == f0 + 1, "R7 fetch after byte", fetch_seen[8:0], 9'(f0 + 1));
    xfer(1'b1, 1'b1, 8'h00, "R7 nibble prefetched high");
    xfer(1'b1, 1'b1, 8'h00, "R7 nibble prefetched low");
    // back to whole bytes (R4)
    put_byte(1'b0, 8'h30, "R4 width to byte");
    exec_busy = 1'b1; exec_ac = 7'h4F;
    xfer(1'b0, 1'b1, 8'h00, "R4 whole byte status");
    // nibble mode, half a read, then reset (R9)
    put_byte(1'b0, 8'h20, "R4 width to nibble again");
    xfer(1'b0, 1'b1, 8'h00, "R6 half read before reset");
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    dl_m = 1'b1; ph_m = 1'b0; dreg_m = 8'h00;
    repeat (2) @(negedge clk);
    xfer(1'b0, 1'b1, 8'h00, "R9 R3 reset restores byte mode");
    xfer(1'b1, 1'b1, 8'h00, "R7 data register reset");
    chk(exp_q.size() == 0, "R10 every command seen once", exp_q.size() * 9'd1, 9'h0);
    finish_run();
  end
endmodule